// File: doc/BRIEF.md
# Deflection Protection Monitor

This block watches the scan stages of a CRT display and decides, on the pixel clock, whether the picture must be blanked and whether horizontal drive may run. It has two supervision paths. The first is a falling-edge watchdog on the vertical flyback feedback line, which is judged once per field at a field-start strobe from the sync logic. The second is a three-state comparator on a digitised safety level, with two programmable thresholds and a separate hysteresis width for each.

The two outputs combine both paths. Either a missing flyback edge or a safety level above the lower threshold raises the RGB blank request. A level above the upper threshold also removes the horizontal drive enable. Software can also choose to blank RGB for as long as the flyback pulse is high. After reset the picture stays blanked and horizontal drive stays off until one complete field containing a flyback edge has been observed.

Top module: `defl_guard`

## Requirements
- R1: After reset, `rgb_blank` is 1 and `hdrive_en` is 0. They stay so until a field-start strobe closes a field in which a flyback falling edge was seen.
- R2: The flyback input passes through a two-flop synchroniser. A 1-to-0 transition of the synchronised value counts as the field's edge, and a field with an edge raises no watchdog blank.
- R3: If a field-start strobe closes a field that had no flyback falling edge, `rgb_blank` is 1 from the following cycle. `hdrive_en` is not affected.
- R4: A watchdog blank is cleared at the field-start strobe that closes the next field containing a flyback falling edge.
- R5: In the normal safety state, a level less than or equal to `thr_lo` keeps that state: no blanking, and horizontal drive on.
- R6: A level above `thr_lo` and not above `thr_hi` gives the blank state: `rgb_blank` is 1 and `hdrive_en` stays 1.
- R7: A level above `thr_hi` gives the shutdown state, with `rgb_blank` 1 and `hdrive_en` 0, starting on the cycle after the level is presented.
- R8: The blank state returns to normal only when the level drops below `thr_lo - hys_lo`, with the difference saturating at 0.
- R9: The shutdown state is left only when the level drops below `thr_hi - hys_hi`, with the difference saturating at 0. The new state is normal if the level is also below `thr_lo - hys_lo`, and blank otherwise.
- R10: When `blank_fly_en` is 1, `rgb_blank` is 1 while the synchronised flyback input is high. When `blank_fly_en` is 0, the flyback level has no effect on `rgb_blank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_start | input | 1 | One-cycle strobe marking the start of each field |
| flyback_in | input | 1 | Asynchronous vertical flyback feedback, high during flyback |
| safety_lvl | input | 8 | Digitised safety level |
| thr_lo | input | 8 | Lower (blank) threshold |
| hys_lo | input | 8 | Hysteresis width of the lower threshold |
| thr_hi | input | 8 | Upper (shutdown) threshold |
| hys_hi | input | 8 | Hysteresis width of the upper threshold |
| blank_fly_en | input | 1 | Blank RGB while flyback is high |
| rgb_blank | output | 1 | RGB blank request |
| hdrive_en | output | 1 | Horizontal drive enable |

## Verification
The hardest cases are the hysteresis edges. Each one needs the comparator to be in a particular state while a level lies inside a band where the result depends on the path taken to reach it. The stimulus therefore moves the level in steps and stops just inside and just outside each band. For the shutdown exit it tests two paths: a fall straight to a low value (to normal) and a fall into the lower band (to blank). The watchdog-recovery case needs a field with no edge followed by a field with an edge. Both are produced by holding `flyback_in` steady across a whole strobe interval, or by pulsing it, before each strobe.

// File: rtl/defl_guard.sv
module defl_guard #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          flyback_in,
  input  logic [LW-1:0] safety_lvl,
  input  logic [LW-1:0] thr_lo,
  input  logic [LW-1:0] hys_lo,
  input  logic [LW-1:0] thr_hi,
  input  logic [LW-1:0] hys_hi,
  input  logic          blank_fly_en,
  output logic          rgb_blank,
  output logic          hdrive_en
);

  typedef enum logic [1:0] {S_OK = 2'd0, S_BLANK = 2'd1, S_SHUT = 2'd2} sstate_t;

  logic fb_m, fb_s, fb_d;
  logic edge_seen, miss_blk, primed;
  logic fall, field_ok;
  sstate_t st, st_nx;
  logic [LW-1:0] lo_exit, hi_exit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fb_m <= 1'b0;
      fb_s <= 1'b0;
      fb_d <= 1'b0;
    end else begin
      fb_m <= flyback_in;
      fb_s <= fb_m;
      fb_d <= fb_s;
    end

  assign fall     = fb_d & ~fb_s;
  assign field_ok = edge_seen | fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_seen <= 1'b0;
      miss_blk  <= 1'b0;
      primed    <= 1'b0;
    end else if (field_start) begin
      edge_seen <= 1'b0;
      miss_blk  <= ~field_ok;
      primed    <= primed | field_ok;
    end else if (fall) begin
      edge_seen <= 1'b1;
    end

  assign lo_exit = (thr_lo >= hys_lo) ? thr_lo - hys_lo : '0;
  assign hi_exit = (thr_hi >= hys_hi) ? thr_hi - hys_hi : '0;

  always_comb begin
    st_nx = st;
    case (st)
      S_OK:
        if (safety_lvl > thr_hi)      st_nx = S_SHUT;
        else if (safety_lvl > thr_lo) st_nx = S_BLANK;
      S_BLANK:
        if (safety_lvl > thr_hi)       st_nx = S_SHUT;
        else if (safety_lvl < lo_exit) st_nx = S_OK;
      S_SHUT:
        if (safety_lvl < hi_exit)
          st_nx = (safety_lvl < lo_exit) ? S_OK : S_BLANK;
      default: st_nx = S_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_OK;
    else        st <= st_nx;

  assign rgb_blank = ~primed | miss_blk | (st != S_OK) | (blank_fly_en & fb_s);
  assign hdrive_en = primed & (st != S_SHUT);

  // The enable may only come up on the cycle after a field strobe (R1).
  p_prime_on_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrive_en) && !$past(st == S_SHUT) |-> $past(field_start));

  // A field without an edge forces the blank request (R3).
  p_missing_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    field_start && !edge_seen && !fall |=> rgb_blank);

  // A level inside the lower band leaves RGB blanked (R6).
  p_mid_band_r6: assert property (@(posedge clk) disable iff (!rst_n)
    safety_lvl > thr_lo && safety_lvl <= thr_hi |=> rgb_blank);

  // A level above the upper threshold turns off the drive (R7).
  p_over_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    safety_lvl > thr_hi |=> !hdrive_en && rgb_blank);

  // Shutdown holds while the level stays at or above the exit point (R9).
  p_shut_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SHUT && safety_lvl >= hi_exit |=> !hdrive_en);

endmodule

// File: tb/sim_defl_guard.sv
module sim_defl_guard;
  localparam time TCK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic field_start = 1'b0, flyback_in = 1'b0, blank_fly_en = 1'b0;
  logic [7:0] safety_lvl = 8'd0;
  logic [7:0] thr_lo = 8'd80, hys_lo = 8'd10, thr_hi = 8'd160, hys_hi = 8'd20;
  logic rgb_blank, hdrive_en;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  defl_guard u0 (.clk, .rst_n, .field_start, .flyback_in, .safety_lvl,
    .thr_lo, .hys_lo, .thr_hi, .hys_hi, .blank_fly_en, .rgb_blank, .hdrive_en);

  task automatic chk(string req, logic exp_b, logic exp_h);
    nchk++;
    if (rgb_blank !== exp_b || hdrive_en !== exp_h) begin
      nfail++;
      $display("FAIL %s: blank/hd = %b/%b expected %b/%b", req, rgb_blank, hdrive_en, exp_b, exp_h);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_field(bit with_edge);
    if (with_edge) begin
      flyback_in = 1'b1; wt(4); flyback_in = 1'b0;
    end
    wt(8);
    field_start = 1'b1; wt(1); field_start = 1'b0;
    wt(2);
  endtask

  task automatic set_lvl(logic [7:0] v);
    safety_lvl = v; wt(2);
  endtask

  task automatic t_reset;
    chk("R1 reset", 1'b1, 1'b0);
    run_field(1'b0);
    chk("R1 no prime without edge", 1'b1, 1'b0);
    run_field(1'b1);
    chk("R2 primed after edge field", 1'b0, 1'b1);
  endtask

  task automatic t_watchdog;
    run_field(1'b0);
    chk("R3 missing edge", 1'b1, 1'b1);
    run_field(1'b1);
    chk("R4 recovery", 1'b0, 1'b1);
  endtask

  task automatic t_levels;
    set_lvl(8'd50);  chk("R5 low level", 1'b0, 1'b1);
    set_lvl(8'd80);  chk("R5 at thr_lo", 1'b0, 1'b1);
    set_lvl(8'd120); chk("R6 mid band", 1'b1, 1'b1);
    set_lvl(8'd75);  chk("R8 inside hysteresis", 1'b1, 1'b1);
    set_lvl(8'd70);  chk("R8 at exit point", 1'b1, 1'b1);
    set_lvl(8'd69);  chk("R8 below exit", 1'b0, 1'b1);
    set_lvl(8'd200); chk("R7 above thr_hi", 1'b1, 1'b0);
    set_lvl(8'd150); chk("R9 inside upper hysteresis", 1'b1, 1'b0);
    set_lvl(8'd139); chk("R9 exit to blank", 1'b1, 1'b1);
    set_lvl(8'd200); chk("R7 reenter shutdown", 1'b1, 1'b0);
    set_lvl(8'd10);  chk("R9 exit to normal", 1'b0, 1'b1);
  endtask

  task automatic t_flyblank;
    blank_fly_en = 1'b1; flyback_in = 1'b1; wt(4);
    chk("R10 blank during flyback", 1'b1, 1'b1);
    flyback_in = 1'b0; wt(4);
    chk("R10 released after flyback", 1'b0, 1'b1);
    blank_fly_en = 1'b0; flyback_in = 1'b1; wt(4);
    chk("R10 option off", 1'b0, 1'b1);
    flyback_in = 1'b0; wt(4);
  endtask

  initial begin
    wt(3);
    rst_n = 1'b1;
    wt(1);
    t_reset;
    t_watchdog;
    t_levels;
    t_flyblank;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule